// File: doc/BRIEF.md
# Byte-Wide SPI Slave Port with Select Synchronization

This block is the receiving end of an SPI link. An external master drives the serial clock, and the port shifts one byte out and one byte in per transfer, most significant bit first. The serial clock, data input and select input are sampled into the system clock domain, and their edges are found there. For this to work, the system clock must run at least four times faster than the serial clock.

The host side of the block does four things:
- writes the next byte to send;
- reads the last byte received;
- drives static configuration inputs: mode, enable, clock polarity and transmit edge;
- watches a completion flag plus overflow and write-collision error flags.

In select mode, the active-low select pin gates the data output and frames each byte. Raising select partway through a byte releases the output and restarts the bit count.

Top module: `spis_port`

## Requirements
- R1: Bits are taken in only on the sampling edge of the synchronized serial clock. The eighth sampled bit ends the byte and sets `done_irq_o`. The flag stays set until `irq_clr_i` is pulsed. If a completion and a clear arrive together, the completion wins.
- R2: The port is active only when `cfg_en_i`=1 and `cfg_mode_i` is 4'b0100 (select mode) or 4'b0101 (free mode). In free mode the select pin is ignored and the output enable stays 1. Any other mode, or `cfg_en_i`=0, leaves the port inactive: output enable is 0, the bit counter is held at 0 and no byte completes.
- R3: In select mode, `sdo_oe_o` is the inverse of the raw `ss_n_i` pin, with no register in the path. It drops to 0 at once when select rises, even partway through a byte.
- R4: In select mode, select high holds the port in reset with the bit counter at 0. A partial byte is discarded without completing, and the next byte after select falls again is framed from its first bit.
- R5: When `cfg_cke_i`=1, the mode must be select mode. The combination of `cfg_cke_i`=1 with free mode makes the port inactive.
- R6: `cfg_ckp_i`=0 means the clock idles low and the leading edge is rising. `cfg_ckp_i`=1 means it idles high and the leading edge is falling.
- R7: With `cfg_cke_i`=0, `sdo_o` shows bit 7 of the loaded byte before the first clock edge. The input is sampled on leading edges, and the output moves to the next bit on trailing edges.
- R8: With `cfg_cke_i`=1, `sdo_o` moves to the next bit on each leading edge, starting with bit 7. The input is sampled on trailing edges.
- R9: On completion, the received byte, first bit in the MSB, appears on `rx_data_o` and is marked unread. A pulse on `rx_rd_i` marks it read.
- R10: If a byte completes while the previous one is still unread, `ovf_o` is set and `rx_data_o` keeps the old byte. `err_clr_i` clears `ovf_o`.
- R11: A `tx_wr_i` pulse while a byte is in progress sets `wcol_o` and does not change the byte being sent. `err_clr_i` clears `wcol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low select |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| cfg_mode_i | input | 4 | Mode field: 4'b0100 selects select mode, 4'b0101 selects free mode |
| cfg_en_i | input | 1 | Port enable |
| cfg_ckp_i | input | 1 | Clock idle level |
| cfg_cke_i | input | 1 | Transmit edge select |
| tx_wr_i | input | 1 | Load strobe for the transmit byte |
| tx_data_i | input | 8 | Byte to transmit |
| rx_rd_i | input | 1 | Read acknowledge for the received byte |
| rx_data_o | output | 8 | Last received byte |
| done_irq_o | output | 1 | Byte completion flag |
| irq_clr_i | input | 1 | Clears the completion flag |
| err_clr_i | input | 1 | Clears the overflow and collision flags |
| ovf_o | output | 1 | Receive overflow flag |
| wcol_o | output | 1 | Write collision flag |

## Verification
The bench aborts a byte after three bits by raising select, then sends a full byte. A design that keeps the stale bit count would complete early and report a misframed byte, and the scoreboard would catch either failure. It also completes two bytes without a read in between: a design that overwrites the buffer would show the second byte where the first must stay. A mid-byte write checks that the outgoing byte is not corrupted. Both edge settings are run under both clock polarities. The illegal pairing of the late edge with free mode is run to show that no byte completes, which a design that ignored the pairing would get wrong.

// File: rtl/spis_pkg.sv
package spis_pkg;
   localparam logic [3:0] SPIS_MODE_SELECT = 4'b0100;
   localparam logic [3:0] SPIS_MODE_FREE   = 4'b0101;

   typedef struct packed {
      logic lead;
      logic trail;
   } spis_sck_ev_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spis_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge
   import spis_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck_s_i,
   input  logic         ckp_i,
   output spis_sck_ev_t ev_o
);
   localparam int WARM_CNT = SYNC_STAGES + 1;
   localparam int WW       = $clog2(WARM_CNT + 1);

   logic          norm, norm_q, ready;
   logic [WW-1:0] warm_q;

   // Normalize so that "1" always means away from the idle level.
   assign norm  = sck_s_i ^ ckp_i;
   assign ready = (warm_q == WW'(WARM_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         norm_q <= 1'b0;
         warm_q <= '0;
      end else begin
         norm_q <= norm;
         if (!ready) warm_q <= warm_q + 1'b1;
      end
   end

   assign ev_o.lead  = ready &  norm & ~norm_q;
   assign ev_o.trail = ready & ~norm &  norm_q;
endmodule

// File: rtl/spis_shifter.sv
module spis_shifter
   import spis_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_rst_i,
   input  logic              cke_i,
   input  spis_sck_ev_t      ev_i,
   input  logic              sdi_s_i,
   input  logic              tx_load_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              busy_o,
   output logic              sdo_bit_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_word_o
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam int LAST  = DATA_W - 1;

   logic [CNT_W-1:0]  bitcnt_q;
   logic [DATA_W-1:0] tx_sr_q, rx_sr_q, rx_next;
   logic              busy_q, hold_q, done_q;
   logic              sample_ev, shift_ev, tx_shift;

   assign sample_ev = cke_i ? ev_i.trail : ev_i.lead;
   assign shift_ev  = cke_i ? ev_i.lead  : ev_i.trail;
   assign rx_next   = {rx_sr_q[DATA_W-2:0], sdi_s_i};
   // With the early setting, the trailing edge after the last sample must not shift.
   assign tx_shift  = !port_rst_i && shift_ev && (cke_i || busy_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt_q <= '0;
         busy_q   <= 1'b0;
         hold_q   <= 1'b0;
         done_q   <= 1'b0;
         rx_sr_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (port_rst_i) begin
            bitcnt_q <= '0;
            busy_q   <= 1'b0;
            hold_q   <= 1'b0;
         end else begin
            if (sample_ev) begin
               rx_sr_q <= rx_next;
               if (bitcnt_q == CNT_W'(LAST)) begin
                  bitcnt_q <= '0;
                  busy_q   <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  bitcnt_q <= bitcnt_q + 1'b1;
                  busy_q   <= 1'b1;
               end
            end
            if (cke_i && shift_ev) begin
               hold_q <= tx_sr_q[DATA_W-1];
               busy_q <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tx_sr_q <= '0;
      else if (tx_load_i) tx_sr_q <= tx_data_i;
      else if (tx_shift)  tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
   end

   assign busy_o    = busy_q;
   assign sdo_bit_o = cke_i ? hold_q : tx_sr_q[DATA_W-1];
   assign done_o    = done_q;
   assign rx_word_o = rx_sr_q;

   assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst_i |=> (bitcnt_q == '0));
   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/spis_hostif.sv
module spis_hostif #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] rx_word_i,
   input  logic              busy_i,
   input  logic              tx_wr_i,
   input  logic              rx_rd_i,
   input  logic              irq_clr_i,
   input  logic              err_clr_i,
   output logic              tx_load_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              irq_o,
   output logic              ovf_o,
   output logic              wcol_o
);
   logic [DATA_W-1:0] rx_buf_q;
   logic              rx_full_q, irq_q, ovf_q, wcol_q, accept;

   assign tx_load_o = tx_wr_i & ~busy_i;
   assign accept    = done_i & (~rx_full_q | rx_rd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf_q  <= '0;
         rx_full_q <= 1'b0;
         irq_q     <= 1'b0;
         ovf_q     <= 1'b0;
         wcol_q    <= 1'b0;
      end else begin
         if (accept) rx_buf_q <= rx_word_i;
         rx_full_q <= accept | (rx_full_q & ~rx_rd_i);
         irq_q     <= done_i | (irq_q & ~irq_clr_i);
         ovf_q     <= (done_i & ~accept) | (ovf_q & ~err_clr_i);
         wcol_q    <= (tx_wr_i & busy_i) | (wcol_q & ~err_clr_i);
      end
   end

   assign rx_data_o = rx_buf_q;
   assign irq_o     = irq_q;
   assign ovf_o     = ovf_q;
   assign wcol_o    = wcol_q;

   assert_rx_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && rx_full_q && !rx_rd_i) |=> $stable(rx_buf_q));
   assert_wcol_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr_i && busy_i) |=> wcol_q);
   assert_irq_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> irq_q);
endmodule

// File: rtl/spis_port.sv
module spis_port
   import spis_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic              ss_n_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   input  logic [3:0]        cfg_mode_i,
   input  logic              cfg_en_i,
   input  logic              cfg_ckp_i,
   input  logic              cfg_cke_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              rx_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              done_irq_o,
   input  logic              irq_clr_i,
   input  logic              err_clr_i,
   output logic              ovf_o,
   output logic              wcol_o
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spis_port: DATA_W must be at least 2");
      end
   endgenerate

   logic              sck_s, sdi_s, ss_s;
   logic              sel_mode, free_mode, active, port_rst;
   logic              busy, done, tx_load, sdo_bit;
   logic [DATA_W-1:0] rx_word;
   spis_sck_ev_t      sck_ev;

   spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ss_n_i, sdi_i, sck_i}),
      .q_o   ({ss_s, sdi_s, sck_s})
   );

   spis_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_s_i (sck_s),
      .ckp_i   (cfg_ckp_i),
      .ev_o    (sck_ev)
   );

   assign sel_mode  = (cfg_mode_i == SPIS_MODE_SELECT);
   assign free_mode = (cfg_mode_i == SPIS_MODE_FREE);
   assign active    = cfg_en_i & (sel_mode | (free_mode & ~cfg_cke_i));
   assign port_rst  = ~active | (sel_mode & ss_s);
   assign sdo_oe_o  = active & (~sel_mode | ~ss_n_i);
   assign sdo_o     = sdo_bit;

   spis_shifter #(.DATA_W(DATA_W)) i_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_rst_i (port_rst),
      .cke_i      (cfg_cke_i),
      .ev_i       (sck_ev),
      .sdi_s_i    (sdi_s),
      .tx_load_i  (tx_load),
      .tx_data_i  (tx_data_i),
      .busy_o     (busy),
      .sdo_bit_o  (sdo_bit),
      .done_o     (done),
      .rx_word_o  (rx_word)
   );

   spis_hostif #(.DATA_W(DATA_W)) i_hostif (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done),
      .rx_word_i (rx_word),
      .busy_i    (busy),
      .tx_wr_i   (tx_wr_i),
      .rx_rd_i   (rx_rd_i),
      .irq_clr_i (irq_clr_i),
      .err_clr_i (err_clr_i),
      .tx_load_o (tx_load),
      .rx_data_o (rx_data_o),
      .irq_o     (done_irq_o),
      .ovf_o     (ovf_o),
      .wcol_o    (wcol_o)
   );

   assert_inactive_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(!active)) |-> !done);
endmodule

// File: tb/test_spis_port.sv
module test_spis_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, sdi = 1'b0, ss_n = 1'b1;
   logic       sdo, sdo_oe;
   logic [3:0] mode = 4'b0000;
   logic       en = 1'b0, ckp = 1'b0, cke = 1'b0;
   logic       tx_wr = 1'b0, rx_rd = 1'b0, irq_clr = 1'b0, err_clr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic [7:0] rx_data;
   logic       irq, ovf, wcol;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_q[$];
   logic       irq_prev = 1'b0;

   localparam int HP = 6;

   always #4 clk = ~clk;

   spis_port i_spis_port (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .ss_n_i(ss_n),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_mode_i(mode), .cfg_en_i(en),
      .cfg_ckp_i(ckp), .cfg_cke_i(cke), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
      .rx_rd_i(rx_rd), .rx_data_o(rx_data), .done_irq_o(irq),
      .irq_clr_i(irq_clr), .err_clr_i(err_clr), .ovf_o(ovf), .wcol_o(wcol)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: every rising completion flag consumes one expected byte.
   always @(negedge clk) begin
      if (rst_n && irq && !irq_prev) begin
         if (exp_q.size() == 0) check("R1 unexpected completion", 1, 0);
         else check("R9 received byte", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
      end
      irq_prev = irq;
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [3:0] m, input logic e, input logic p, input logic k);
      @(negedge clk);
      en = 1'b0;
      mode = m; ckp = p; cke = k; sck = p;
      wait_clk(HP);
      en = e;
      wait_clk(2);
   endtask

   task automatic load(input logic [7:0] v);
      @(negedge clk);
      tx_data = v; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic ack(input logic do_rd);
      @(negedge clk);
      irq_clr = 1'b1; rx_rd = do_rd;
      @(negedge clk);
      irq_clr = 1'b0; rx_rd = 1'b0;
   endtask

   task automatic clear_err();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   // Master model: drives the clock and data in, collects the data out.
   task automatic xfer(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
      miso = 8'h00;
      if (!cke) begin
         @(negedge clk);
         sdi = mosi[7];
         wait_clk(HP);
         for (int i = 0; i < nbits; i++) begin
            miso[7-i] = sdo;
            sck = ~ckp;
            wait_clk(HP);
            sck = ckp;
            if (i < 7) sdi = mosi[6-i];
            wait_clk(HP);
         end
      end else begin
         for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck = ~ckp;
            sdi = mosi[7-i];
            wait_clk(HP);
            miso[7-i] = sdo;
            sck = ckp;
            wait_clk(HP);
         end
      end
      wait_clk(HP);
   endtask

   task automatic run_byte(input logic [7:0] txv, input logic [7:0] mosi,
                           input logic [7:0] exp_rx, input string req, input logic do_rd);
      logic [7:0] miso;
      load(txv);
      if (mode == 4'b0100) begin ss_n = 1'b0; wait_clk(4); end
      exp_q.push_back(exp_rx);
      xfer(mosi, 8, miso);
      if (mode == 4'b0100) ss_n = 1'b1;
      check({req, " data out"}, {24'h0, miso}, {24'h0, txv});
      ack(do_rd);
   endtask

   initial begin
      logic [7:0] m;
      wait_clk(5);
      check("R2 reset oe", {31'h0, sdo_oe}, 0);
      check("R1 reset irq", {31'h0, irq}, 0);
      check("R10 reset ovf", {31'h0, ovf}, 0);
      check("R11 reset wcol", {31'h0, wcol}, 0);
      rst_n = 1'b1;
      wait_clk(5);

      // R7 / R2 free mode, select pin high but ignored
      cfg(4'b0101, 1'b1, 1'b0, 1'b0);
      ss_n = 1'b1;
      check("R2 free mode oe", {31'h0, sdo_oe}, 1);
      run_byte(8'hA5, 8'h3C, 8'h3C, "R7 ckp0", 1'b1);
      // R6 idle high
      cfg(4'b0101, 1'b1, 1'b1, 1'b0);
      run_byte(8'h81, 8'h7E, 8'h7E, "R6 ckp1 cke0", 1'b1);
      // R8 select mode, late edge, both polarities
      cfg(4'b0100, 1'b1, 1'b0, 1'b1);
      run_byte(8'h5B, 8'hC6, 8'hC6, "R8 ckp0", 1'b1);
      cfg(4'b0100, 1'b1, 1'b1, 1'b1);
      run_byte(8'h2D, 8'hE1, 8'hE1, "R8 ckp1", 1'b1);
      // R7 select mode, early edge
      cfg(4'b0100, 1'b1, 1'b0, 1'b0);
      run_byte(8'hF7, 8'h09, 8'h09, "R7 select", 1'b1);

      // R3: output enable follows the select pin immediately
      ss_n = 1'b0; #1;
      check("R3 oe on select low", {31'h0, sdo_oe}, 1);
      ss_n = 1'b1; #1;
      check("R3 oe off select high", {31'h0, sdo_oe}, 0);

      // R4: abort after three bits, then a full byte frames from bit 7
      cfg(4'b0100, 1'b1, 1'b0, 1'b1);
      load(8'hF0);
      ss_n = 1'b0; wait_clk(4);
      xfer(8'hFF, 3, m);
      ss_n = 1'b1; #1;
      check("R3 oe released mid-byte", {31'h0, sdo_oe}, 0);
      wait_clk(HP);
      check("R4 no completion on abort", {31'h0, irq}, 0);
      run_byte(8'h5A, 8'h96, 8'h96, "R4 reframed", 1'b1);

      // R5: late edge with free mode is inactive
      cfg(4'b0101, 1'b1, 1'b0, 1'b1);
      check("R5 oe inactive", {31'h0, sdo_oe}, 0);
      xfer(8'hAA, 8, m);
      check("R5 no completion", {31'h0, irq}, 0);

      // R2: unsupported mode and disabled port
      cfg(4'b0110, 1'b1, 1'b0, 1'b0);
      check("R2 other mode oe", {31'h0, sdo_oe}, 0);
      xfer(8'h55, 8, m);
      check("R2 other mode no completion", {31'h0, irq}, 0);
      cfg(4'b0100, 1'b0, 1'b0, 1'b0);
      ss_n = 1'b0; #1;
      check("R2 disabled oe", {31'h0, sdo_oe}, 0);
      ss_n = 1'b1;

      // R10: second byte completes before the first is read
      cfg(4'b0101, 1'b1, 1'b0, 1'b0);
      run_byte(8'h11, 8'h4D, 8'h4D, "R10 first", 1'b0);
      run_byte(8'h22, 8'hB2, 8'h4D, "R10 second", 1'b0);
      check("R10 overflow flag", {31'h0, ovf}, 1);
      check("R10 buffer kept", {24'h0, rx_data}, {24'h0, 8'h4D});
      clear_err();
      check("R10 overflow cleared", {31'h0, ovf}, 0);
      ack(1'b1);

      // R11: write in the middle of a byte is refused
      load(8'hC3);
      exp_q.push_back(8'h6E);
      fork
         xfer(8'h6E, 8, m);
         begin wait_clk(40); load(8'h00); end
      join
      check("R11 data out unchanged", {24'h0, m}, {24'h0, 8'hC3});
      check("R11 collision flag", {31'h0, wcol}, 1);
      ack(1'b1);
      clear_err();
      check("R11 collision cleared", {31'h0, wcol}, 0);

      wait_clk(10);
      check("R9 all bytes seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule